// File: doc/BRIEF.md
# Programmable Pixel Clock Divider

This block derives a panel pixel clock from a reference clock. A configuration word supplies a pass-through flag and a divide code split into a low field and a high field. With pass-through set, the reference clock is forwarded unchanged. Otherwise the two fields are joined into one code and the reference clock is divided by that code plus two.

Alongside the generated clock the block gives a single-cycle enable in the reference domain. Logic that runs on the reference clock can use it to act once per pixel period without crossing clock domains. A divide of one has no field encoding and is reached only through the pass-through flag.

Configuration changes are picked up only at a period boundary, so a change never shortens or stretches the period already running. Reset holds the output clock low and clears the period counter.

Top module: `pixel_clk_div`

## Requirements
- R1: While `rst_n` is low, `pix_clk` and `pix_ce` are both 0.
- R2: With `bypass_en` at 0, the divide code is `{div_hi, div_lo}`: `div_hi` supplies the upper bits and `div_lo` the lower bits. The output period is code + 2 reference cycles.
- R3: For a ratio N, `pix_clk` is high for floor(N/2) reference cycles of each period and low for the remaining N - floor(N/2) cycles.
- R4: `pix_ce` is 1 for exactly one reference cycle per output period. That cycle is the first cycle in which `pix_clk` is high.
- R5: Once pass-through is in effect, `pix_clk` follows `ref_clk` and `pix_ce` is 1 in every cycle. Changes to `div_lo` and `div_hi` have no effect while it lasts.
- R6: A new setting applies from the next period start. The period in progress keeps the ratio it started with.
- R7: Code 0 gives a ratio of 2. The all-ones code (2^(LO_W+HI_W) - 1) gives a ratio of 2^(LO_W+HI_W) + 1.
- R8: A 1 in the lowest bit of `div_hi` adds 2^LO_W to the ratio. With LO_W = 5, for example, `div_hi` = 1 and `div_lo` = 7 give a ratio of 41.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | Pass-through flag (divide by one) |
| div_lo | input | LO_W | Low bits of the divide code |
| div_hi | input | HI_W | High bits of the divide code |
| pix_clk | output | 1 | Generated pixel clock |
| pix_ce | output | 1 | One-cycle enable per pixel period, reference domain |

## Verification
The bench uses the default widths, five bits for each field. This gives a ten-bit code, so the all-ones setting runs a 1025-cycle period within a short run. With fields this narrow, one bench can also reach the smallest ratio of 2, odd and even ratios, and a high-field bit whose weight is visibly separate from the low field. Each setting change is applied at a period start, so the period that follows each change shows whether the old ratio was held.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;

  // Ratio produced by a joined divide code in the divided mode.
  function automatic int unsigned ratio_of(input int unsigned code);
    return code + 32'd2;
  endfunction

  // Number of high reference cycles for a given ratio.
  function automatic int unsigned high_len(input int unsigned ratio);
    return ratio >> 1;
  endfunction

endpackage

// File: rtl/pixdiv_cfg_decode.sv
module pixdiv_cfg_decode #(
  parameter int LO_W = 5,
  parameter int HI_W = 5,
  localparam int CODE_W = LO_W + HI_W,
  localparam int RATIO_W = CODE_W + 1
) (
  input  logic               bypass_en,
  input  logic [LO_W-1:0]    div_lo,
  input  logic [HI_W-1:0]    div_hi,
  output logic               req_byp,
  output logic [RATIO_W-1:0] req_ratio
);
  import pixdiv_pkg::*;

  logic [CODE_W-1:0] code;

  // High field forms the upper bits of the joined code.
  assign code      = {div_hi, div_lo};
  assign req_ratio = RATIO_W'(ratio_of(32'(code)));
  assign req_byp   = bypass_en;

  always_comb begin
    if (!req_byp) begin
      a_r2_ratio_floor: assert (req_ratio >= RATIO_W'(2))
        else $error("requested ratio below 2");
    end
  end

endmodule

// File: rtl/pixdiv_phase_ctr.sv
module pixdiv_phase_ctr #(
  parameter int RATIO_W = 11
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               req_byp,
  input  logic [RATIO_W-1:0] req_ratio,
  output logic               act_byp,
  output logic               pix_q,
  output logic               pix_ce
);
  import pixdiv_pkg::*;

  logic               started;
  logic [RATIO_W-1:0] act_ratio;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] cnt_inc;
  logic [RATIO_W-1:0] act_high;
  logic               period_end;
  logic               period_start;

  assign cnt_inc      = cnt + RATIO_W'(1);
  assign act_high     = RATIO_W'(high_len(32'(act_ratio)));
  assign period_end   = (cnt == act_ratio - RATIO_W'(1));
  assign period_start = !started || act_byp || period_end;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      act_byp   <= 1'b0;
      act_ratio <= RATIO_W'(2);
      cnt       <= '0;
      pix_q     <= 1'b0;
      pix_ce    <= 1'b0;
    end else if (period_start) begin
      started   <= 1'b1;
      act_byp   <= req_byp;
      act_ratio <= req_ratio;
      cnt       <= '0;
      pix_q     <= !req_byp;
      pix_ce    <= 1'b1;
    end else begin
      cnt       <= cnt_inc;
      pix_q     <= (cnt_inc < act_high);
      pix_ce    <= 1'b0;
    end
  end

  // R3: the phase counter never leaves the active period
  a_r3_cnt_in_period: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cnt < act_ratio);

  // R4: the divided clock rises only together with the enable
  a_r4_rise_has_ce: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(pix_q) |-> pix_ce);

  // R4: enable in divided mode sits in a high cycle
  a_r4_ce_in_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pix_ce && !act_byp) |-> pix_q);

  // R6: ratio is held for the whole period once counting has moved on
  a_r6_ratio_held: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(act_ratio));

  // R5: pass-through fires the enable every cycle and parks the divided phase
  a_r5_pass_ce: assert property (@(posedge ref_clk) disable iff (!rst_n)
    act_byp |-> (pix_ce && !pix_q));

  // R2: divided mode always runs with a ratio of at least two
  a_r2_min_ratio: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !act_byp |-> (act_ratio >= RATIO_W'(2)));

endmodule

// File: rtl/pixdiv_clk_out.sv
module pixdiv_clk_out (
  input  logic ref_clk,
  input  logic act_byp,
  input  logic pix_q,
  output logic pix_clk
);

  assign pix_clk = act_byp ? ref_clk : pix_q;

endmodule

// File: rtl/pixel_clk_div.sv
module pixel_clk_div #(
  parameter int LO_W = 5,
  parameter int HI_W = 5,
  localparam int CODE_W = LO_W + HI_W,
  localparam int RATIO_W = CODE_W + 1
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic            bypass_en,
  input  logic [LO_W-1:0] div_lo,
  input  logic [HI_W-1:0] div_hi,
  output logic            pix_clk,
  output logic            pix_ce
);

  logic               req_byp;
  logic [RATIO_W-1:0] req_ratio;
  logic               act_byp;
  logic               pix_q;

  pixdiv_cfg_decode #(.LO_W(LO_W), .HI_W(HI_W)) u_decode (
    .bypass_en (bypass_en),
    .div_lo    (div_lo),
    .div_hi    (div_hi),
    .req_byp   (req_byp),
    .req_ratio (req_ratio)
  );

  pixdiv_phase_ctr #(.RATIO_W(RATIO_W)) u_phase (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .req_byp   (req_byp),
    .req_ratio (req_ratio),
    .act_byp   (act_byp),
    .pix_q     (pix_q),
    .pix_ce    (pix_ce)
  );

  pixdiv_clk_out u_out (
    .ref_clk (ref_clk),
    .act_byp (act_byp),
    .pix_q   (pix_q),
    .pix_clk (pix_clk)
  );

  // R1: reset holds both outputs low
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!pix_q && !pix_ce && !act_byp)
        else $error("outputs active in reset");
    end
  end

endmodule

// File: tb/pixel_clk_div_bench.sv
module pixel_clk_div_bench;
  localparam int LO_W = 5;
  localparam int HI_W = 5;

  logic            ref_clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bypass_en = 1'b0;
  logic [LO_W-1:0] div_lo = '0;
  logic [HI_W-1:0] div_hi = '0;
  logic            pix_clk;
  logic            pix_ce;

  pixel_clk_div #(.LO_W(LO_W), .HI_W(HI_W)) u_pixel_clk_div (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .bypass_en (bypass_en),
    .div_lo    (div_lo),
    .div_hi    (div_hi),
    .pix_clk   (pix_clk),
    .pix_ce    (pix_ce)
  );

  always #2 ref_clk = ~ref_clk;

  typedef struct {
    int    hi;
    int    tot;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   mon_en = 1'b1;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Ratio written as weight arithmetic instead of field concatenation.
  function automatic int want_ratio(input int lo, input int hi);
    return hi * (1 << LO_W) + lo + 2;
  endfunction

  task automatic wait_rises(input int n);
    bit prev = pix_clk;
    int seen = 0;
    while (seen < n) begin
      @(posedge ref_clk); #1;
      if (pix_clk && !prev) seen++;
      prev = pix_clk;
    end
  endtask

  task automatic push_exp(input int lo, input int hi, input int nper, input string tag);
    int r = want_ratio(lo, hi);
    for (int i = 0; i < nper; i++) begin
      exp_t e;
      e.tot = r;
      e.hi  = (r - (r % 2)) / 2;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // Applies a setting right after a period start; the running period keeps its ratio.
  task automatic run_cfg(input int lo, input int hi, input int nper, input string tag);
    if (exp_q.size() > 0) exp_q[exp_q.size()-1].tag = "R6";
    div_lo = LO_W'(lo);
    div_hi = HI_W'(hi);
    push_exp(lo, hi, nper, tag);
    wait_rises(nper);
  endtask

  // Monitor: measures each full period and compares with the scoreboard.
  initial begin
    bit prev = 1'b0;
    bit have_start = 1'b0;
    int hi_c = 0;
    int tot_c = 0;
    int ce_c = 0;
    forever begin
      @(posedge ref_clk); #1;
      if (!mon_en) begin
        have_start = 1'b0;
        prev = 1'b1;
      end else begin
        bit rise = pix_clk && !prev;
        if (rise) begin
          if (have_start) begin
            if (exp_q.size() == 0) begin
              check(1'b0, "R2", tot_c, 0, "unexpected period");
            end else begin
              exp_t e = exp_q.pop_front();
              check(tot_c == e.tot, {e.tag, " R2 period"}, tot_c, e.tot, "length");
              check(hi_c == e.hi, {e.tag, " R3 high phase"}, hi_c, e.hi, "length");
              check(ce_c == 1, "R4 enables per period", ce_c, 1, "count");
            end
          end
          have_start = 1'b1;
          hi_c = 0;
          tot_c = 0;
          ce_c = 0;
          check(pix_ce == 1'b1, "R4 enable at rise", int'(pix_ce), 1, "level");
        end
        if (have_start) begin
          tot_c++;
          if (pix_clk) hi_c++;
          if (pix_ce) ce_c++;
        end
        prev = pix_clk;
      end
    end
  end

  // Driver
  initial begin
    div_lo = LO_W'(3);
    div_hi = '0;
    for (int i = 0; i < 4; i++) begin
      @(posedge ref_clk); #1;
      check(pix_clk == 1'b0, "R1 reset clock", int'(pix_clk), 0, "level");
      check(pix_ce == 1'b0, "R1 reset enable", int'(pix_ce), 0, "level");
    end
    rst_n = 1'b1;
    push_exp(3, 0, 4, "R2");
    wait_rises(4);
    run_cfg(0, 0, 4, "R7");
    run_cfg(4, 0, 3, "R3");
    run_cfg(1, 0, 3, "R3");
    run_cfg(7, 1, 2, "R8");
    run_cfg(31, 31, 2, "R7");
    run_cfg(5, 0, 3, "R2");

    // R5: pass-through, with divide fields changing underneath
    mon_en = 1'b0;
    bypass_en = 1'b1;
    exp_q.delete();
    repeat (12) @(posedge ref_clk);
    for (int i = 0; i < 8; i++) begin
      #1;
      check(pix_clk == 1'b1, "R5 pass high phase", int'(pix_clk), 1, "level");
      check(pix_ce == 1'b1, "R5 pass enable", int'(pix_ce), 1, "level");
      div_lo = LO_W'(i * 3 + 1);
      div_hi = HI_W'(i);
      #2;
      check(pix_clk == 1'b0, "R5 pass low phase", int'(pix_clk), 0, "level");
      @(posedge ref_clk);
    end
    #1;
    bypass_en = 1'b0;
    div_lo = LO_W'(2);
    div_hi = '0;
    mon_en = 1'b1;
    push_exp(2, 0, 3, "R5");
    wait_rises(3);
    run_cfg(0, 0, 2, "R7");
    repeat (4) @(posedge ref_clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule